// File: doc/BRIEF.md
# Debounced Indicator Conditioner

This block turns one digital input pin into a drive signal for an indicator LED. The pin is first optionally inverted. The result is then passed through a run-length filter. The filtered level moves to a new value only after that value has been seen for a programmable number of consecutive clock samples. The count for settling high and the count for settling low are set separately, so the filter can reject short spikes in one direction while still passing short drops in the other.

The LED shows the filtered signal in one of two ways. In level mode it shows the filtered level directly. In edge mode it stays dark and lights for a fixed stretch of cycles each time the filtered level changes, so that rare or very short events become visible to the eye. With the intended 125 MHz sample clock, a count of 125,000,000 gives one second of settling. The default pulse length of 12,500,000 cycles gives 100 ms.

The pin is assumed to be synchronous to the sample clock already. Counters are 27 bits wide by default.

Top module: `pin_led_cond`

## Requirements
- R1: While `rst_n` is low the LED output is 0, and the filtered level starts at 0 after reset is released.
- R2: In level mode (`edge_mode_i`=0), a sample level changing from 0 to 1 and holding is shown on `led_o` after the clock edge that captures the N-th consecutive 1 sample, where N is `hi_cnt_i`. One cycle earlier the LED still shows 0.
- R3: The same rule applies for a change from 1 to 0, using `lo_cnt_i` as N.
- R4: Any sample equal to the current filtered level restarts the run. A burst of opposite samples shorter than the applicable count never changes the output, even when bursts repeat with single-sample gaps.
- R5: A count value of 0 behaves exactly like a count of 1.
- R6: In level mode with both counts at 1, `led_o` after each clock edge equals the sample taken at that edge, so the output is the input delayed by one register.
- R7: The sample level is `pin_i` XOR `invert_i`, formed before the filter. The high count applies when this inverted level is 1.
- R8: In edge mode (`edge_mode_i`=1), every change of the filtered level, in either direction, drives `led_o` high for exactly `PULSE_LEN` cycles. The pulse starts right after the edge on which the filtered level changes. Otherwise the LED is 0.
- R9: A filtered change that occurs while a pulse is still running restarts the pulse at its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw input pin, already synchronous to `clk` |
| invert_i | input | 1 | 1 inverts the pin ahead of the filter |
| edge_mode_i | input | 1 | 0 = level display, 1 = edge pulse display |
| hi_cnt_i | input | CNT_W | Consecutive 1 samples needed to settle high (0 acts as 1) |
| lo_cnt_i | input | CNT_W | Consecutive 0 samples needed to settle low (0 acts as 1) |
| led_o | output | 1 | LED drive |

## Verification
Two situations are hard to reach. The first is a run that gets within one sample of its count and is then broken by a single matching sample. The bench reaches it by timing its pin changes in whole cycles against the programmed count, so a burst stops exactly one sample short before restarting, in both directions. The second is a pulse restart in edge mode, which needs a second filtered change to land in the middle of a running pulse. The bench uses a short pulse length and small counts so that the second change is scheduled well inside the first pulse. It then checks that the LED stays lit past the point where the first pulse alone would have ended.

// File: rtl/ledc_pkg.sv
package ledc_pkg;

   // Default counter width: 2**27 exceeds one second of samples at 125 MHz.
   localparam int unsigned DEF_CNT_W     = 27;
   // Default edge pulse: 100 ms at 125 MHz.
   localparam int unsigned DEF_PULSE_LEN = 12_500_000;

   typedef enum logic {
      SHOW_LEVEL = 1'b0,
      SHOW_EDGE  = 1'b1
   } show_mode_e;

   // Index into the pair of settling counts, chosen by the target level.
   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } level_e;

endpackage

// File: rtl/ledc_polarity.sv
module ledc_polarity (
   input  logic pin_i,
   input  logic invert_i,
   output logic samp_o
);
   // The polarity flip sits ahead of everything else.
   always_comb samp_o = pin_i ^ invert_i;
endmodule

// File: rtl/ledc_run_filter.sv
module ledc_run_filter #(
   parameter int unsigned CNT_W = ledc_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             samp_i,
   input  logic [CNT_W-1:0] hi_cnt_i,
   input  logic [CNT_W-1:0] lo_cnt_i,
   output logic             filt_o,
   output logic             flip_o,
   output logic [CNT_W-1:0] run_o,
   output logic [CNT_W-1:0] need_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam int unsigned      NLVL = 2;

   logic [CNT_W-1:0] raw_cnt [NLVL];
   logic [CNT_W-1:0] eff_cnt [NLVL];
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_inc;
   logic [CNT_W-1:0] need;
   logic             filt_q;
   logic             differs;

   always_comb begin
      raw_cnt[ledc_pkg::LVL_LOW]  = lo_cnt_i;
      raw_cnt[ledc_pkg::LVL_HIGH] = hi_cnt_i;
   end

   // Normalize each settling count: zero requests the fastest response.
   for (genvar g = 0; g < NLVL; g++) begin : g_norm
      always_comb eff_cnt[g] = (raw_cnt[g] == '0) ? ONE : raw_cnt[g];
   end

   always_comb begin
      need    = eff_cnt[samp_i];
      differs = samp_i ^ filt_q;
      run_inc = run_q + ONE;
      flip_o  = differs && (run_inc >= need);
   end

   // run_q counts opposing samples seen so far; it stays below the
   // largest count, so the increment cannot wrap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b0;
         run_q  <= '0;
      end else if (flip_o) begin
         filt_q <= samp_i;
         run_q  <= '0;
      end else if (!differs) begin
         run_q  <= '0;
      end else begin
         run_q  <= run_inc;
      end
   end

   assign filt_o = filt_q;
   assign run_o  = run_q;
   assign need_o = need;
endmodule

// File: rtl/ledc_edge_stretch.sv
module ledc_edge_stretch #(
   parameter int unsigned PULSE_LEN = ledc_pkg::DEF_PULSE_LEN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic pulse_o
);
   localparam int unsigned PW = (PULSE_LEN < 2) ? 1 : $clog2(PULSE_LEN + 1);

   if (PULSE_LEN == 1) begin : g_single
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q <= 1'b0;
         else        hit_q <= fire_i;
      end
      assign pulse_o = hit_q;
   end else begin : g_count
      localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN);
      logic [PW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              left_q <= '0;
         else if (fire_i)         left_q <= LOAD;
         else if (left_q != '0)   left_q <= left_q - PW'(1);
      end
      assign pulse_o = (left_q != '0);
   end
endmodule

// File: rtl/pin_led_cond.sv
module pin_led_cond #(
   parameter int unsigned CNT_W     = ledc_pkg::DEF_CNT_W,
   parameter int unsigned PULSE_LEN = ledc_pkg::DEF_PULSE_LEN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_i,
   input  logic             invert_i,
   input  logic             edge_mode_i,
   input  logic [CNT_W-1:0] hi_cnt_i,
   input  logic [CNT_W-1:0] lo_cnt_i,
   output logic             led_o
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("pin_led_cond: CNT_W must lie in 1..32");
   end
   if (PULSE_LEN < 1) begin : g_bad_pulse
      $error("pin_led_cond: PULSE_LEN must be at least 1");
   end

   logic                 samp_w;
   logic                 filt_w;
   logic                 flip_w;
   logic                 pulse_w;
   logic [CNT_W-1:0]     run_w;
   logic [CNT_W-1:0]     need_w;
   ledc_pkg::show_mode_e mode;

   ledc_polarity u_pol (
      .pin_i    (pin_i),
      .invert_i (invert_i),
      .samp_o   (samp_w)
   );

   ledc_run_filter #(.CNT_W(CNT_W)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .samp_i   (samp_w),
      .hi_cnt_i (hi_cnt_i),
      .lo_cnt_i (lo_cnt_i),
      .filt_o   (filt_w),
      .flip_o   (flip_w),
      .run_o    (run_w),
      .need_o   (need_w)
   );

   ledc_edge_stretch #(.PULSE_LEN(PULSE_LEN)) u_stretch (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (flip_w),
      .pulse_o (pulse_w)
   );

   always_comb begin
      mode = ledc_pkg::show_mode_e'(edge_mode_i);
      unique case (mode)
         ledc_pkg::SHOW_EDGE: led_o = pulse_w;
         default:             led_o = filt_w;
      endcase
   end
endmodule

// File: rtl/pin_led_cond_chk.sv
module pin_led_cond_chk #(
   parameter int unsigned CNT_W = ledc_pkg::DEF_CNT_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pin_i,
   input logic             invert_i,
   input logic             edge_mode_i,
   input logic [CNT_W-1:0] hi_cnt_i,
   input logic [CNT_W-1:0] lo_cnt_i,
   input logic             led_o,
   input logic             filt_i,
   input logic [CNT_W-1:0] run_i
);
   logic wire_like;
   always_comb wire_like = !edge_mode_i && (hi_cnt_i <= CNT_W'(1)) && (lo_cnt_i <= CNT_W'(1));

   // R1: the first edge after reset still sees a dark LED.
   p_reset_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !led_o);

   // R2, R3, R7: the filtered level only moves to the value of the sample just taken.
   p_flip_follows_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_i != $past(filt_i)) |-> ($past(pin_i ^ invert_i) == filt_i));

   // R4: an open run means the last sample disagreed with the filtered level.
   p_run_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i != '0) |-> ($past(pin_i ^ invert_i) != filt_i));

   // R6 (and R5 for zero counts): wire-like behaviour.
   p_wire_like_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wire_like && $past(wire_like) && $past(rst_n)) |-> (led_o == $past(pin_i ^ invert_i)));

   // R8: in edge mode the LED only lights when the filtered level changes.
   p_edge_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode_i && $past(edge_mode_i) && $rose(led_o)) |-> (filt_i != $past(filt_i)));
endmodule

bind pin_led_cond pin_led_cond_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pin_i       (pin_i),
   .invert_i    (invert_i),
   .edge_mode_i (edge_mode_i),
   .hi_cnt_i    (hi_cnt_i),
   .lo_cnt_i    (lo_cnt_i),
   .led_o       (led_o),
   .filt_i      (filt_w),
   .run_i       (run_w)
);

// File: tb/pin_led_cond_bench.sv
module pin_led_cond_bench;
   localparam int unsigned CNT_W = 27;
   localparam int unsigned PLEN  = 20;

   typedef struct {
      int    cyc;
      logic  val;
      string tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pin = 1'b0;
   logic             inv = 1'b0;
   logic             edm = 1'b0;
   logic [CNT_W-1:0] hi = '0;
   logic [CNT_W-1:0] lo = '0;
   logic             led;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   exp_t sb[$];

   pin_led_cond #(.CNT_W(CNT_W), .PULSE_LEN(PLEN)) u_pin_led_cond (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (pin),
      .invert_i    (inv),
      .edge_mode_i (edm),
      .hi_cnt_i    (hi),
      .lo_cnt_i    (lo),
      .led_o       (led)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compares led after edge number c against items for cycle c.
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].cyc == cyc) begin
            checks++;
            if (led !== sb[i].val) begin
               errors++;
               $display("FAIL %s cycle %0d led actual %b expected %b", sb[i].tag, cyc, led, sb[i].val);
            end
            sb.delete(i);
         end else if (sb[i].cyc < cyc) begin
            checks++;
            errors++;
            $display("FAIL %s cycle %0d missed, actual none expected %b", sb[i].tag, sb[i].cyc, sb[i].val);
            sb.delete(i);
         end
      end
   end

   task automatic push(input int c, input logic v, input string t);
      exp_t e;
      e.cyc = c; e.val = v; e.tag = t;
      sb.push_back(e);
   endtask

   task automatic push_span(input int c0, input int c1, input logic v, input string t);
      for (int c = c0; c <= c1; c++) push(c, v, t);
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int k;
      hi = CNT_W'(5);
      lo = CNT_W'(3);
      // R1: dark during reset and on the first cycle after.
      @(negedge clk);
      push_span(cyc + 1, cyc + 3, 1'b0, "R1");
      idle(4);
      rst_n = 1'b1;
      push_span(cyc + 1, cyc + 2, 1'b0, "R1");
      drain();

      // R2: rise after 5 consecutive high samples.
      @(negedge clk); k = cyc + 1;
      push(k + 3, 1'b0, "R2"); push(k + 4, 1'b1, "R2");
      pin = 1'b1;
      drain();

      // R3: fall after 3 consecutive low samples.
      @(negedge clk); k = cyc + 1;
      push(k + 1, 1'b1, "R3"); push(k + 2, 1'b0, "R3");
      pin = 1'b0;
      drain();

      // R4: high bursts one short of the count with a one-sample gap.
      @(negedge clk); k = cyc + 1;
      push_span(k, k + 12, 1'b0, "R4");
      pin = 1'b1; idle(4);
      pin = 1'b0; idle(1);
      pin = 1'b1; idle(4);
      pin = 1'b0;
      drain();
      // R4: low side, after settling high.
      pin = 1'b1; idle(8);
      @(negedge clk); k = cyc + 1;
      push_span(k, k + 8, 1'b1, "R4");
      pin = 1'b0; idle(2);
      pin = 1'b1; idle(1);
      pin = 1'b0; idle(2);
      pin = 1'b1;
      drain();
      // R4/R3: a held drop still settles after the gap.
      @(negedge clk); k = cyc + 1;
      push(k + 1, 1'b1, "R4"); push(k + 2, 1'b0, "R4");
      pin = 1'b0;
      drain();

      // R5: zero counts act as one.
      hi = '0; lo = '0;
      idle(2);
      @(negedge clk); k = cyc + 1;
      push(k - 1, 1'b0, "R5"); push(k, 1'b1, "R5");
      pin = 1'b1;
      drain();
      @(negedge clk); k = cyc + 1;
      push(k, 1'b0, "R5");
      pin = 1'b0;
      drain();

      // R6: counts of 1 give the input delayed by one register.
      hi = CNT_W'(1); lo = CNT_W'(1);
      idle(2);
      begin
         logic [11:0] pat;
         pat = 12'b1011_0011_1010;
         @(negedge clk); k = cyc + 1;
         for (int i = 0; i < 12; i++) push(k + i, pat[i], "R6");
         for (int i = 0; i < 12; i++) begin
            pin = pat[i];
            @(negedge clk);
         end
      end
      pin = 1'b0;
      drain();

      // R7: invert before the filter; high count applies to the inverted level.
      hi = CNT_W'(5); lo = CNT_W'(3);
      idle(4);
      @(negedge clk); k = cyc + 1;
      push(k + 3, 1'b0, "R7"); push(k + 4, 1'b1, "R7");
      inv = 1'b1;
      drain();
      @(negedge clk); k = cyc + 1;
      push(k + 1, 1'b1, "R7"); push(k + 2, 1'b0, "R7");
      pin = 1'b1;
      drain();
      pin = 1'b0; inv = 1'b0;
      idle(PLEN + 5);

      // R8: edge mode pulses on each filtered change, dark otherwise.
      hi = CNT_W'(2); lo = CNT_W'(2);
      edm = 1'b1;
      @(negedge clk); k = cyc + 1;
      push_span(k, k + 3, 1'b0, "R8");
      drain();
      @(negedge clk); k = cyc + 1;
      push(k, 1'b0, "R8");
      push_span(k + 1, k + PLEN, 1'b1, "R8");
      push_span(k + PLEN + 1, k + PLEN + 4, 1'b0, "R8");
      pin = 1'b1;
      drain();
      @(negedge clk); k = cyc + 1;
      push(k, 1'b0, "R8");
      push_span(k + 1, k + PLEN, 1'b1, "R8");
      push(k + PLEN + 1, 1'b0, "R8");
      pin = 1'b0;
      drain();

      // R9: a second change inside the pulse restarts it.
      @(negedge clk); k = cyc + 1;
      push_span(k + 1, k + 11 + PLEN - 1, 1'b1, "R9");
      push(k + 11 + PLEN, 1'b0, "R9");
      pin = 1'b1;
      idle(10);
      pin = 1'b0;
      drain();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule